// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD. It counts seconds, minutes, hours, day of week, day of month, month and year, plus a century flag. A prescaler divides a 32.768 kHz enable stream into a once-per-second advance. The same prescaler drives a 1 Hz square wave that is low for the first half of each second and high for the second half.

A host loads any field through a byte-wide write port. The seven fields sit at addresses 0 to 6: seconds, minutes, hours, day of week, date, month, year. A write to the seconds field restarts the sub-second count. Reads go through a shadow copy that changes only when the host pulses a load strobe. The host pulses it when a bus transaction starts or when its read pointer wraps to zero. A multi-byte read therefore sees one consistent instant while the live counters keep running.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, both the live fields and the shadow copy hold seconds 00, minutes 00, hours 00 in 24-hour mode, day of week 01, date 01, month 01 with the century bit (month bit 7) clear, and year 00. The square wave is low.
- R2: Seconds and minutes count in BCD, so 09 steps to 10. Each wraps from 59 to 00 and carries into the next field up.
- R3: With hours bit 6 clear (24-hour mode), bits 5:0 hold BCD hours 00 to 23 and bit 5 is the tens digit 2. Hour 23 wraps to 00 and advances the date.
- R4: With hours bit 6 set (12-hour mode), bits 4:0 hold BCD hours 01 to 12 and bit 5 is set for PM. The steps are 11 AM to 12 PM, 12 PM to 1 PM and 12 AM to 1 AM. The step from 11 PM to 12 AM advances the date.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. The month then advances, with 09 stepping to 10.
- R6: In month 02 the date wraps after 29 when the year is a multiple of 4 (00 counts) and after 28 otherwise.
- R7: After 31 December the date becomes 01 January. Year 99 wraps to 00 and toggles the century bit in month bit 7. The century bit keeps its value in every other year step.
- R8: Day of week advances once per day change, 1 through 7, with 7 wrapping to 1.
- R9: A write loads its field with the byte in the next cycle. A seconds write also clears the sub-second count, even when it lands on the last enable of a second, so the next advance comes exactly the prescale number of enables after the write.
- R10: The square wave is low while the sub-second count is in its first half and high in its second half. It rises half the prescale count of enables after a seconds write.
- R11: The shadow copy changes only on the load strobe, when it captures all seven live fields at once. Reads return shadow bytes by address, and addresses 7 and up return 00.
- R12: The fields advance by exactly one second per prescale count of input enables, and never between enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wrEn | input | 1 | Field write strobe |
| wrAddr | input | 3 | Field address for a write, 0 to 6 |
| wrData | input | 8 | Packed BCD byte to load |
| snapLoad | input | 1 | Copies the live fields into the shadow copy |
| rdAddr | input | 3 | Shadow field address for a read |
| rdData | output | 8 | Shadow byte at rdAddr, combinational |
| sqwOut | output | 1 | 1 Hz square wave |

## Verification
Writes, enables and load strobes are registered and take effect at the next rising edge. The read port is combinational from the shadow copy, so its byte is valid in the same cycle as the address. The square wave comes straight from the sub-second count and changes at the edge that takes the relevant enable. The bench drives every stimulus at a falling edge and samples one falling edge later, after exactly one register stage. It uses a prescale count of 4, so a second is four enables, and the half-second rise of the square wave falls on the second enable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DOW   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;

  // reset contents, index 6 (year) first
  localparam logic [NUM_FIELDS-1:0][7:0] FIELD_INIT =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  typedef struct packed {
    logic                  secTick;
    logic [NUM_FIELDS-1:0] fieldWr;
    logic                  snapLoad;
  } rtcStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last legal date of a month, BCD; century bit ignored
  function automatic logic [7:0] monthLast(input logic [7:0] mon,
                                           input logic [7:0] yr);
    logic [1:0] mod4;
    mod4 = yr[1:0] + {yr[4], 1'b0};
    case (mon[4:0])
      5'h02:                      return (mod4 == 2'd0) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic       snapReq,
  output rtcStrobe_t strobes,
  output logic       sqwOut
);

  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(PRESCALE / 2);

  logic [CNT_W-1:0] presCnt;
  logic [NUM_FIELDS-1:0] fieldWr;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
    assign fieldWr[i] = wrEn && (wrAddr == 3'(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              presCnt <= '0;
    else if (fieldWr[F_SEC]) presCnt <= '0;
    else if (tick32k)        presCnt <= (presCnt == LAST) ? '0 : presCnt + 1'b1;
  end

  always_comb begin
    strobes.secTick  = tick32k && (presCnt == LAST) && !fieldWr[F_SEC];
    strobes.fieldWr  = fieldWr;
    strobes.snapLoad = snapReq;
  end

  assign sqwOut = (presCnt >= HALF);

  assert_cnt_range_R12: assert property (@(posedge clk) disable iff (!rstN)
    presCnt <= LAST);

  assert_secwr_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    fieldWr[F_SEC] |=> (presCnt == '0));

  assert_sqw_on_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sqwOut) |-> ($past(tick32k) || $past(fieldWr[F_SEC])));

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  rtcStrobe_t strobes,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData
);

  logic [NUM_FIELDS-1:0][7:0] liveQ, advD, snapQ;

  always_comb begin
    logic minC, hrC, dayC, monC, yrC;
    logic [7:0] hr, incd;
    advD = liveQ;
    minC = 1'b0; hrC = 1'b0; dayC = 1'b0; monC = 1'b0; yrC = 1'b0;
    hr = liveQ[F_HOUR];
    incd = 8'h00;

    if (liveQ[F_SEC] == 8'h59) begin advD[F_SEC] = 8'h00; minC = 1'b1; end
    else advD[F_SEC] = bcdInc(liveQ[F_SEC]);

    if (minC) begin
      if (liveQ[F_MIN] == 8'h59) begin advD[F_MIN] = 8'h00; hrC = 1'b1; end
      else advD[F_MIN] = bcdInc(liveQ[F_MIN]);
    end

    if (hrC) begin
      if (hr[6]) begin
        incd = bcdInc({3'b000, hr[4:0]});
        if (hr[4:0] == 5'h11) begin
          advD[F_HOUR] = {2'b01, ~hr[5], 5'h12};
          dayC = hr[5];
        end else if (hr[4:0] == 5'h12) advD[F_HOUR] = {2'b01, hr[5], 5'h01};
        else advD[F_HOUR] = {2'b01, hr[5], incd[4:0]};
      end else begin
        incd = bcdInc({2'b00, hr[5:0]});
        if (hr[5:0] == 6'h23) begin advD[F_HOUR] = 8'h00; dayC = 1'b1; end
        else advD[F_HOUR] = {2'b00, incd[5:0]};
      end
    end

    if (dayC) begin
      advD[F_DOW] = (liveQ[F_DOW] == 8'h07) ? 8'h01 : bcdInc(liveQ[F_DOW]);
      if (liveQ[F_DATE] == monthLast(liveQ[F_MONTH], liveQ[F_YEAR])) begin
        advD[F_DATE] = 8'h01; monC = 1'b1;
      end else advD[F_DATE] = bcdInc(liveQ[F_DATE]);
    end

    if (monC) begin
      if (liveQ[F_MONTH][4:0] == 5'h12) begin
        advD[F_MONTH] = {liveQ[F_MONTH][7], 7'h01}; yrC = 1'b1;
      end else advD[F_MONTH] = {liveQ[F_MONTH][7], 2'b00, bcdInc({3'b000, liveQ[F_MONTH][4:0]})[4:0]};
    end

    if (yrC) begin
      if (liveQ[F_YEAR] == 8'h99) begin
        advD[F_YEAR] = 8'h00;
        advD[F_MONTH][7] = ~liveQ[F_MONTH][7];
      end else advD[F_YEAR] = bcdInc(liveQ[F_YEAR]);
    end
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   liveQ[i] <= FIELD_INIT[i];
      else if (strobes.fieldWr[i]) liveQ[i] <= wrData;
      else if (strobes.secTick)    liveQ[i] <= advD[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 snapQ[i] <= FIELD_INIT[i];
      else if (strobes.snapLoad) snapQ[i] <= liveQ[i];
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (rdAddr == 3'(i)) rdData = snapQ[i];
  end

  assert_snap_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.snapLoad |=> $stable(snapQ));

  assert_sec_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.secTick && !strobes.fieldWr[F_SEC]) |=> $stable(liveQ[F_SEC]));

  assert_century_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(liveQ[F_MONTH][7]) |->
      ($past(strobes.fieldWr[F_MONTH]) ||
       ($past(liveQ[F_YEAR]) == 8'h99 && liveQ[F_YEAR] == 8'h00)));

  assert_dow_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (liveQ[F_DOW] >= 8'h01) && (liveQ[F_DOW] <= 8'h07));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick32k,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       snapLoad,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  output logic       sqwOut
);

  rtcStrobe_t strobes;

  rtc_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn),
    .wrAddr(wrAddr), .snapReq(snapLoad), .strobes(strobes), .sqwOut(sqwOut)
  );

  rtc_datapath u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;

  localparam int PS = 4;
  localparam int NV = 26;

  typedef struct packed {
    logic [3:0]  req;
    logic [55:0] start;  // sec,min,hr,dow,date,mon,yr
    logic [55:0] expv;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd2, 56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00}, // R2
    '{4'd2, 56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00}, // R2
    '{4'd2, 56'h59_59_05_01_01_01_00, 56'h00_00_06_01_01_01_00}, // R2
    '{4'd2, 56'h59_09_05_01_01_01_00, 56'h00_10_05_01_01_01_00}, // R2
    '{4'd3, 56'h59_59_23_03_14_05_21, 56'h00_00_00_04_15_05_21}, // R3
    '{4'd3, 56'h59_59_09_03_14_05_21, 56'h00_00_10_03_14_05_21}, // R3
    '{4'd3, 56'h59_59_19_03_14_05_21, 56'h00_00_20_03_14_05_21}, // R3
    '{4'd4, 56'h59_59_51_02_10_03_22, 56'h00_00_72_02_10_03_22}, // R4
    '{4'd4, 56'h59_59_72_02_10_03_22, 56'h00_00_61_02_10_03_22}, // R4
    '{4'd4, 56'h59_59_71_02_10_03_22, 56'h00_00_52_03_11_03_22}, // R4
    '{4'd4, 56'h59_59_49_02_10_03_22, 56'h00_00_50_02_10_03_22}, // R4
    '{4'd4, 56'h59_59_52_02_10_03_22, 56'h00_00_41_02_10_03_22}, // R4
    '{4'd5, 56'h59_59_23_05_30_04_21, 56'h00_00_00_06_01_05_21}, // R5
    '{4'd5, 56'h59_59_23_05_30_01_21, 56'h00_00_00_06_31_01_21}, // R5
    '{4'd5, 56'h59_59_23_05_30_09_21, 56'h00_00_00_06_01_10_21}, // R5
    '{4'd5, 56'h59_59_23_05_31_07_21, 56'h00_00_00_06_01_08_21}, // R5
    '{4'd6, 56'h59_59_23_05_28_02_23, 56'h00_00_00_06_01_03_23}, // R6
    '{4'd6, 56'h59_59_23_05_28_02_24, 56'h00_00_00_06_29_02_24}, // R6
    '{4'd6, 56'h59_59_23_05_29_02_24, 56'h00_00_00_06_01_03_24}, // R6
    '{4'd6, 56'h59_59_23_05_28_02_00, 56'h00_00_00_06_29_02_00}, // R6
    '{4'd6, 56'h59_59_23_05_28_02_10, 56'h00_00_00_06_01_03_10}, // R6
    '{4'd6, 56'h59_59_23_05_28_02_12, 56'h00_00_00_06_29_02_12}, // R6
    '{4'd7, 56'h59_59_23_05_31_12_99, 56'h00_00_00_06_01_81_00}, // R7
    '{4'd7, 56'h59_59_23_05_31_92_99, 56'h00_00_00_06_01_01_00}, // R7
    '{4'd7, 56'h59_59_23_05_31_12_98, 56'h00_00_00_06_01_01_99}, // R7
    '{4'd8, 56'h59_59_23_07_10_06_30, 56'h00_00_00_01_11_06_30}  // R8
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick32k = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic snapLoad = 1'b0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic sqwOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_rtc_core #(.PRESCALE(PS)) u_dut (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .snapLoad(snapLoad),
    .rdAddr(rdAddr), .rdData(rdData), .sqwOut(sqwOut)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [55:0] act, input logic [55:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic writeField(input int a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = 3'(a); wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic enables(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick32k = 1'b1;
      @(negedge clk); tick32k = 1'b0;
    end
  endtask

  task automatic doSnap();
    @(negedge clk); snapLoad = 1'b1;
    @(negedge clk); snapLoad = 1'b0;
  endtask

  task automatic readAll(output logic [55:0] v);
    v = '0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); rdAddr = 3'(i); #1;
      v[55-8*i -: 8] = rdData;
    end
  endtask

  task automatic loadAll(input logic [55:0] v);
    for (int i = 1; i < 7; i++) writeField(i, v[55-8*i -: 8]);
    writeField(0, v[55:48]);
  endtask

  task automatic readOne(input int a, output logic [7:0] b);
    @(negedge clk); rdAddr = 3'(a); #1; b = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [55:0] got;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: shadow before any load, then after a load
    readAll(got);
    check(got == 56'h00_00_00_01_01_01_00, "R1 shadow reset", got, 56'h00_00_00_01_01_01_00);
    doSnap(); readAll(got);
    check(got == 56'h00_00_00_01_01_01_00, "R1 live reset", got, 56'h00_00_00_01_01_01_00);
    check(sqwOut == 1'b0, "R1 sqw reset", {55'd0, sqwOut}, 56'd0);

    // table walk: load, one second, snapshot, compare
    for (int v = 0; v < NV; v++) begin
      loadAll(VECS[v].start);
      enables(PS);
      doSnap(); readAll(got);
      check(got == VECS[v].expv, $sformatf("R%0d vector %0d", VECS[v].req, v), got, VECS[v].expv);
    end

    // R12: one advance per PS enables
    writeField(0, 8'h10);
    enables(PS - 1); doSnap(); readOne(0, b);
    check(b == 8'h10, "R12 before full second", {48'd0, b}, 56'h10);
    enables(1); doSnap(); readOne(0, b);
    check(b == 8'h11, "R12 at full second", {48'd0, b}, 56'h11);
    enables(PS); doSnap(); readOne(0, b);
    check(b == 8'h12, "R12 second period", {48'd0, b}, 56'h12);

    // R9: mid-second seconds write restarts the count
    enables(2);
    writeField(0, 8'h30);
    enables(PS - 1); doSnap(); readOne(0, b);
    check(b == 8'h30, "R9 restart holds", {48'd0, b}, 56'h30);
    enables(1); doSnap(); readOne(0, b);
    check(b == 8'h31, "R9 restart advance", {48'd0, b}, 56'h31);

    // R9: seconds write on the last enable of a second wins, no advance
    enables(PS - 1);
    @(negedge clk); tick32k = 1'b1; wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h20;
    @(negedge clk); tick32k = 1'b0; wrEn = 1'b0;
    doSnap(); readOne(0, b);
    check(b == 8'h20, "R9 write beats advance", {48'd0, b}, 56'h20);
    enables(PS - 1); doSnap(); readOne(0, b);
    check(b == 8'h20, "R9 full period after collision", {48'd0, b}, 56'h20);
    writeField(1, 8'h45); doSnap(); readOne(1, b);
    check(b == 8'h45, "R9 minute load", {48'd0, b}, 56'h45);

    // R10: square wave phase after a seconds write
    writeField(0, 8'h00);
    check(sqwOut == 1'b0, "R10 low after write", {55'd0, sqwOut}, 56'd0);
    enables(1);
    check(sqwOut == 1'b0, "R10 low first quarter", {55'd0, sqwOut}, 56'd0);
    enables(1);
    check(sqwOut == 1'b1, "R10 rise at half", {55'd0, sqwOut}, 56'd1);
    enables(1);
    check(sqwOut == 1'b1, "R10 high second half", {55'd0, sqwOut}, 56'd1);
    enables(1);
    check(sqwOut == 1'b0, "R10 low at new second", {55'd0, sqwOut}, 56'd0);

    // R11: shadow frozen without a load strobe, then refreshed
    writeField(0, 8'h40); doSnap();
    enables(PS);
    readOne(0, b);
    check(b == 8'h40, "R11 shadow held", {48'd0, b}, 56'h40);
    doSnap(); readOne(0, b);
    check(b == 8'h41, "R11 shadow refreshed", {48'd0, b}, 56'h41);
    readOne(7, b);
    check(b == 8'h00, "R11 unused address", {48'd0, b}, 56'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule